// File: doc/BRIEF.md
# Load Queue Memory-Order Violation Detector

This block tracks in-flight loads in a circular queue and detects when a load has run ahead of an older memory operation to the same region. Each slot holds a live flag, an address-known flag, the load's effective address and its instruction sequence number. Loads are allocated at the tail in program order, get their address filled in later when they execute, and leave from the head when they retire.

When a store or a load executes, the pipeline presents the executing instruction's slot index and address. In a single cycle the block examines every live, address-known slot younger than that index, up to the tail. It compares addresses at 256-byte block granularity and takes the nearest matching slot as the candidate. The candidate is recorded as the violator, so that the pipeline can squash and refetch from it, unless an older violator is already recorded. A squash carrying a sequence number removes the recorded violator once that violator lies on the squashed path.

Top module: `lq_order_guard`

## Requirements
- R1: After reset the queue is empty, no violator is recorded (`violatorHeld` = 0), `violationValid` = 0 and `violationCount` = 0.
- R2: A store check at index I searches the live slots that follow I in circular order, stopping before the tail. If one of them conflicts, `violationValid` is 1 in the cycle after the check, and `violatorIndex` and `violatorSeq` then show that slot and its sequence number.
- R3: Two addresses conflict when bits [ADDR_W-1:8] are equal. A slot whose address has not been set since it was last allocated never conflicts, even when an earlier occupant of that slot left a matching address behind.
- R4: When several younger slots conflict, the one nearest after I in circular order is chosen.
- R5: A load check runs the same search. It has no effect when `checkFault` or `queueBlocked` is 1 in that cycle: no pulse, and the recorded violator and the counter stay unchanged.
- R6: While a violator is recorded, the chosen slot replaces it only if its sequence number is numerically smaller. Otherwise the check reports nothing and the recorded violator stays unchanged.
- R7: A squash with sequence number S clears the recorded violator when S is smaller than the recorded sequence number. When S is equal or larger, the violator is kept. If a squash and a check arrive in the same cycle, the check is judged against the state left after the squash.
- R8: `violationCount` rises by exactly one in each cycle in which `violationValid` is 1 and does not change otherwise.
- R9: Slot indices wrap modulo DEPTH, in the search and in the head and tail pointers. Allocation is ignored when the queue is full, and retirement is ignored when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a slot at the tail |
| allocSeq | input | SEQ_W | Sequence number of the allocated load |
| setAddrValid | input | 1 | Write an address into a live slot |
| setAddrIdx | input | log2(DEPTH) | Slot that receives the address |
| setAddr | input | ADDR_W | Effective address |
| retireValid | input | 1 | Free the head slot |
| checkValid | input | 1 | An ordering check is presented |
| checkIsLoad | input | 1 | 1 = load check, 0 = store check |
| checkIdx | input | log2(DEPTH) | Queue index of the checking instruction |
| checkAddr | input | ADDR_W | Address of the checking instruction |
| checkFault | input | 1 | The checking load faulted |
| queueBlocked | input | 1 | The queue is blocked this cycle |
| squashValid | input | 1 | A squash is presented |
| squashSeq | input | SEQ_W | Sequence number of the squash point |
| violationValid | output | 1 | One-cycle pulse: a violation was recorded |
| violatorHeld | output | 1 | A violator is currently recorded |
| violatorIndex | output | log2(DEPTH) | Slot of the recorded violator |
| violatorSeq | output | SEQ_W | Sequence number of the recorded violator |
| violationCount | output | CNT_W | Number of reported violations |

## Verification
The hardest case to reach is a suppressed match. This needs a recorded violator and then a second check whose nearest conflicting slot is younger than that violator. It must be followed by a check whose nearest conflict is older, so that the replacement happens. The directed part builds this by giving addresses to chosen slots and then checking from different indices. It also refills slots that still hold stale conflicting addresses and presents squashes exactly at and just below the recorded sequence number. The random part draws addresses from only four 256-byte blocks, so conflicts, suppressions and wrapped searches happen often.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Strobes from the decision logic to the entry/violator storage
  typedef struct packed {
    logic record;  // capture picked slot as violator and pulse
    logic clear;   // drop the recorded violator (squash)
  } lqStrobe_t;
endpackage

// File: rtl/lq_entries.sv
module lq_entries
  import lq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        allocValid,
  input  logic [SEQ_W-1:0]            allocSeq,
  input  logic                        setAddrValid,
  input  logic [IDX_W-1:0]            setAddrIdx,
  input  logic [ADDR_W-1:0]           setAddr,
  input  logic                        retireValid,
  input  logic [ADDR_W-1:0]           checkAddr,
  input  lqStrobe_t                   strobe,
  input  logic [IDX_W-1:0]            pickIdx,
  output logic [DEPTH-1:0]            hitVec,
  output logic [DEPTH-1:0][SEQ_W-1:0] seqArr,
  output logic [IDX_W-1:0]            tailPtr,
  output logic                        violationValid,
  output logic                        violatorHeld,
  output logic [IDX_W-1:0]            violatorIndex,
  output logic [SEQ_W-1:0]            violatorSeq,
  output logic [CNT_W-1:0]            violationCount
);
  localparam logic [IDX_W:0] FULL_FILL = (IDX_W+1)'(DEPTH);

  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  entAddrOk;
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [SEQ_W-1:0]  entSeq  [DEPTH];
  logic [IDX_W-1:0]  headPtr;
  logic [IDX_W:0]    fillLvl;
  logic              allocOk;
  logic              retireOk;

  assign allocOk  = allocValid  && (fillLvl != FULL_FILL);
  assign retireOk = retireValid && (fillLvl != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid  <= '0;
      entAddrOk <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
      fillLvl   <= '0;
    end else begin
      if (setAddrValid && entValid[setAddrIdx]) begin
        entAddr[setAddrIdx]   <= setAddr;
        entAddrOk[setAddrIdx] <= 1'b1;
      end
      if (retireOk) begin
        entValid[headPtr]  <= 1'b0;
        entAddrOk[headPtr] <= 1'b0;
        headPtr            <= headPtr + 1'b1;
      end
      if (allocOk) begin
        entValid[tailPtr]  <= 1'b1;
        entAddrOk[tailPtr] <= 1'b0;
        entSeq[tailPtr]    <= allocSeq;
        tailPtr            <= tailPtr + 1'b1;
      end
      fillLvl <= fillLvl + (IDX_W+1)'(allocOk) - (IDX_W+1)'(retireOk);
    end
  end

  // Per-slot block-granular comparator
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [ADDR_W-1:0] addrDiff;
    assign addrDiff  = entAddr[g] ^ checkAddr;
    assign hitVec[g] = entValid[g] && entAddrOk[g] && ((addrDiff >> BLK_SHIFT) == '0);
    assign seqArr[g] = entSeq[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violationValid <= 1'b0;
      violatorHeld   <= 1'b0;
      violatorIndex  <= '0;
      violatorSeq    <= '0;
      violationCount <= '0;
    end else begin
      violationValid <= strobe.record;
      if (strobe.record) begin
        violatorHeld   <= 1'b1;
        violatorIndex  <= pickIdx;
        violatorSeq    <= entSeq[pickIdx];
        violationCount <= violationCount + 1'b1;
      end else if (strobe.clear) begin
        violatorHeld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        checkValid,
  input  logic                        checkIsLoad,
  input  logic [IDX_W-1:0]            checkIdx,
  input  logic                        checkFault,
  input  logic                        queueBlocked,
  input  logic                        squashValid,
  input  logic [SEQ_W-1:0]            squashSeq,
  input  logic [DEPTH-1:0]            hitVec,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqArr,
  input  logic [IDX_W-1:0]            tailPtr,
  input  logic                        violatorHeld,
  input  logic [SEQ_W-1:0]            violatorSeq,
  output lqStrobe_t                   strobe,
  output logic [IDX_W-1:0]            pickIdx
);
  logic             searchEn;
  logic [IDX_W-1:0] tailDist;
  logic [IDX_W:0]   youngCnt;
  logic             found;
  logic [IDX_W-1:0] slot;
  logic             squashHit;
  logic             heldAfterSquash;
  logic             pickOlder;

  assign searchEn = checkValid && (!checkIsLoad || (!checkFault && !queueBlocked));

  // Number of slots strictly between checkIdx and tail (tail==idx means full wrap)
  assign tailDist = tailPtr - checkIdx;
  assign youngCnt = (tailDist == '0) ? (IDX_W+1)'(DEPTH - 1)
                                     : ({1'b0, tailDist} - (IDX_W+1)'(1));

  // Age-ordered priority pick: nearest slot after checkIdx wins
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    slot    = '0;
    for (int k = 0; k < DEPTH - 1; k++) begin
      slot = checkIdx + IDX_W'(k + 1);
      if (!found && ((IDX_W+1)'(k) < youngCnt) && hitVec[slot]) begin
        found   = 1'b1;
        pickIdx = slot;
      end
    end
  end

  assign squashHit       = squashValid && violatorHeld && (squashSeq < violatorSeq);
  assign heldAfterSquash = violatorHeld && !squashHit;
  assign pickOlder       = seqArr[pickIdx] < violatorSeq;

  assign strobe.record = searchEn && found && (!heldAfterSquash || pickOlder);
  assign strobe.clear  = squashHit;
endmodule

// File: rtl/lq_order_guard.sv
module lq_order_guard
  import lq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic              setAddrValid,
  input  logic [IDX_W-1:0]  setAddrIdx,
  input  logic [ADDR_W-1:0] setAddr,
  input  logic              retireValid,
  input  logic              checkValid,
  input  logic              checkIsLoad,
  input  logic [IDX_W-1:0]  checkIdx,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic              checkFault,
  input  logic              queueBlocked,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  output logic              violationValid,
  output logic              violatorHeld,
  output logic [IDX_W-1:0]  violatorIndex,
  output logic [SEQ_W-1:0]  violatorSeq,
  output logic [CNT_W-1:0]  violationCount
);
  lqStrobe_t                   strobe;
  logic [IDX_W-1:0]            pickIdx;
  logic [DEPTH-1:0]            hitVec;
  logic [DEPTH-1:0][SEQ_W-1:0] seqArr;
  logic [IDX_W-1:0]            tailPtr;

  lq_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uCtrl (
    .checkValid   (checkValid),
    .checkIsLoad  (checkIsLoad),
    .checkIdx     (checkIdx),
    .checkFault   (checkFault),
    .queueBlocked (queueBlocked),
    .squashValid  (squashValid),
    .squashSeq    (squashSeq),
    .hitVec       (hitVec),
    .seqArr       (seqArr),
    .tailPtr      (tailPtr),
    .violatorHeld (violatorHeld),
    .violatorSeq  (violatorSeq),
    .strobe       (strobe),
    .pickIdx      (pickIdx)
  );

  lq_entries #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W),
    .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT)
  ) uEntries (
    .clk            (clk),
    .rstN           (rstN),
    .allocValid     (allocValid),
    .allocSeq       (allocSeq),
    .setAddrValid   (setAddrValid),
    .setAddrIdx     (setAddrIdx),
    .setAddr        (setAddr),
    .retireValid    (retireValid),
    .checkAddr      (checkAddr),
    .strobe         (strobe),
    .pickIdx        (pickIdx),
    .hitVec         (hitVec),
    .seqArr         (seqArr),
    .tailPtr        (tailPtr),
    .violationValid (violationValid),
    .violatorHeld   (violatorHeld),
    .violatorIndex  (violatorIndex),
    .violatorSeq    (violatorSeq),
    .violationCount (violationCount)
  );
endmodule

// File: rtl/lq_order_guard_chk.sv
module lq_order_guard_chk #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             checkValid,
  input logic             checkIsLoad,
  input logic             checkFault,
  input logic             queueBlocked,
  input logic             squashValid,
  input logic [SEQ_W-1:0] squashSeq,
  input logic             violationValid,
  input logic             violatorHeld,
  input logic [SEQ_W-1:0] violatorSeq,
  input logic [CNT_W-1:0] violationCount
);
  assert_pulse_needs_check_R2: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !violationValid);

  assert_gated_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && checkIsLoad && (checkFault || queueBlocked)) |=> !violationValid);

  assert_pulse_sets_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    violationValid |-> violatorHeld);

  assert_only_older_replaces_R6: assert property (@(posedge clk) disable iff (!rstN)
    (violatorHeld && !squashValid) |=> (!violationValid || (violatorSeq < $past(violatorSeq))));

  assert_squash_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && violatorHeld && (squashSeq < violatorSeq) && !checkValid) |=> !violatorHeld);

  assert_count_steps_R8: assert property (@(posedge clk) disable iff (!rstN)
    violationValid |-> (violationCount == CNT_W'($past(violationCount) + 1'b1)));

  assert_count_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !violationValid |-> $stable(violationCount));
endmodule

bind lq_order_guard lq_order_guard_chk #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .checkValid     (checkValid),
  .checkIsLoad    (checkIsLoad),
  .checkFault     (checkFault),
  .queueBlocked   (queueBlocked),
  .squashValid    (squashValid),
  .squashSeq      (squashSeq),
  .violationValid (violationValid),
  .violatorHeld   (violatorHeld),
  .violatorSeq    (violatorSeq),
  .violationCount (violationCount)
);

// File: tb/sim_lq_order_guard.sv
module sim_lq_order_guard;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int SEQ_W  = 16;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 3;

  logic              clk;
  logic              rstN;
  logic              allocValid;
  logic [SEQ_W-1:0]  allocSeq;
  logic              setAddrValid;
  logic [IDX_W-1:0]  setAddrIdx;
  logic [ADDR_W-1:0] setAddr;
  logic              retireValid;
  logic              checkValid;
  logic              checkIsLoad;
  logic [IDX_W-1:0]  checkIdx;
  logic [ADDR_W-1:0] checkAddr;
  logic              checkFault;
  logic              queueBlocked;
  logic              squashValid;
  logic [SEQ_W-1:0]  squashSeq;
  logic              violationValid;
  logic              violatorHeld;
  logic [IDX_W-1:0]  violatorIndex;
  logic [SEQ_W-1:0]  violatorSeq;
  logic [CNT_W-1:0]  violationCount;

  lq_order_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSeq(allocSeq),
    .setAddrValid(setAddrValid), .setAddrIdx(setAddrIdx), .setAddr(setAddr),
    .retireValid(retireValid), .checkValid(checkValid), .checkIsLoad(checkIsLoad),
    .checkIdx(checkIdx), .checkAddr(checkAddr), .checkFault(checkFault),
    .queueBlocked(queueBlocked), .squashValid(squashValid), .squashSeq(squashSeq),
    .violationValid(violationValid), .violatorHeld(violatorHeld),
    .violatorIndex(violatorIndex), .violatorSeq(violatorSeq),
    .violationCount(violationCount)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // Reference model state
  bit               mValid [DEPTH];
  bit               mAv    [DEPTH];
  logic [ADDR_W-1:0] mAddr [DEPTH];
  logic [SEQ_W-1:0]  mSeq  [DEPTH];
  int               mHead, mTail, mFill;
  bit               mHeld, mFlag;
  int               mHIdx;
  logic [SEQ_W-1:0] mHSeq;
  logic [CNT_W-1:0] mCnt;
  logic [SEQ_W-1:0] nextSeq;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  task automatic zeroIn();
    allocValid = 0; allocSeq = '0; setAddrValid = 0; setAddrIdx = '0; setAddr = '0;
    retireValid = 0; checkValid = 0; checkIsLoad = 0; checkIdx = '0; checkAddr = '0;
    checkFault = 0; queueBlocked = 0; squashValid = 0; squashSeq = '0;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Evaluate model for driven inputs, clock once, compare outputs
  task automatic doCycle(string tag);
    bit sq, effHeld, en, found, ra, aa;
    int pk;
    sq      = squashValid && mHeld && (squashSeq < mHSeq);
    effHeld = mHeld && !sq;
    en      = checkValid && (!checkIsLoad || (!checkFault && !queueBlocked));
    found   = 0;
    pk      = 0;
    if (checkValid) chk(tag, "checker slot live (no squashed instruction)", 32'(mValid[checkIdx]), 32'd1);
    if (en) begin
      for (int k = 1; k < DEPTH; k++) begin
        int s;
        s = (int'(checkIdx) + k) % DEPTH;
        if (s == mTail) break;
        if (mValid[s] && mAv[s] && ((mAddr[s] >> 8) == (checkAddr >> 8))) begin
          found = 1; pk = s; break;
        end
      end
    end
    mFlag = en && found && (!effHeld || (mSeq[pk] < mHSeq));
    @(posedge clk); #1;
    if (mFlag) begin
      mHeld = 1; mHIdx = pk; mHSeq = mSeq[pk]; mCnt = mCnt + 1'b1;
    end else if (sq) begin
      mHeld = 0;
    end
    ra = retireValid && (mFill > 0);
    aa = allocValid && (mFill < DEPTH);
    if (setAddrValid && mValid[setAddrIdx]) begin
      mAddr[setAddrIdx] = setAddr; mAv[setAddrIdx] = 1;
    end
    if (ra) begin
      mValid[mHead] = 0; mAv[mHead] = 0; mHead = (mHead + 1) % DEPTH;
    end
    if (aa) begin
      mValid[mTail] = 1; mAv[mTail] = 0; mSeq[mTail] = allocSeq; mTail = (mTail + 1) % DEPTH;
    end
    mFill = mFill + int'(aa) - int'(ra);
    chk(tag, "violationValid", 32'(violationValid), 32'(mFlag));
    chk(tag, "violatorHeld", 32'(violatorHeld), 32'(mHeld));
    if (mHeld) begin
      chk(tag, "violatorIndex", 32'(violatorIndex), 32'(mHIdx));
      chk(tag, "violatorSeq", 32'(violatorSeq), 32'(mHSeq));
    end
    chk(tag, "violationCount", 32'(violationCount), 32'(mCnt));
    @(negedge clk);
    zeroIn();
  endtask

  task automatic doAlloc(string tag);
    allocValid = 1; allocSeq = nextSeq; nextSeq = nextSeq + 1'b1; doCycle(tag);
  endtask
  task automatic doRetire(string tag);
    retireValid = 1; doCycle(tag);
  endtask
  task automatic doSetAddr(int idx, logic [31:0] a, string tag);
    setAddrValid = 1; setAddrIdx = IDX_W'(idx); setAddr = a; doCycle(tag);
  endtask
  task automatic doCheck(bit ld, int idx, logic [31:0] a, bit flt, bit blk, string tag);
    checkValid = 1; checkIsLoad = ld; checkIdx = IDX_W'(idx); checkAddr = a;
    checkFault = flt; queueBlocked = blk; doCycle(tag);
  endtask
  task automatic doSquash(logic [SEQ_W-1:0] s, string tag);
    squashValid = 1; squashSeq = s; doCycle(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    zeroIn();
    rstN = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mAv[i] = 0; mAddr[i] = '0; mSeq[i] = '0;
    end
    mHead = 0; mTail = 0; mFill = 0; mHeld = 0; mFlag = 0; mHIdx = 0;
    mHSeq = '0; mCnt = '0; nextSeq = 16'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk("R1", "violationValid", 32'(violationValid), 0);
    chk("R1", "violatorHeld", 32'(violatorHeld), 0);
    chk("R1", "violationCount", 32'(violationCount), 0);
    doCycle("R1");

    // R3: stale addresses left by earlier occupants never match
    for (int i = 0; i < DEPTH; i++) doAlloc("R3");
    for (int i = 0; i < DEPTH; i++) doSetAddr(i, 32'h500 + i, "R3");
    for (int i = 0; i < DEPTH; i++) doRetire("R3");
    for (int i = 0; i < DEPTH; i++) doAlloc("R3");
    doAlloc("R9");                                   // full: ignored
    doCheck(0, 0, 32'h5FF, 0, 0, "R3");              // expect no violation
    doCheck(1, 2, 32'h5FF, 0, 0, "R3");

    // R4: nearest conflicting younger slot wins
    doSetAddr(3, 32'h510, "R4");
    doSetAddr(5, 32'h520, "R4");
    doCheck(0, 1, 32'h500, 0, 0, "R4");              // slot 3

    // R6: younger match suppressed, older match replaces
    doCheck(1, 2, 32'h5AA, 0, 0, "R6");              // slot 3 again, not older
    doCheck(0, 4, 32'h500, 0, 0, "R6");              // slot 5, younger: none
    doSetAddr(1, 32'h530, "R6");
    doCheck(0, 0, 32'h500, 0, 0, "R6");              // slot 1, older: record

    // R7: squash boundary
    doSquash(mHSeq, "R7");                           // equal: kept
    doSquash(mHSeq + 16'd5, "R7");                   // larger: kept
    doSquash(mHSeq - 16'd1, "R7");                   // smaller: cleared

    // R5: load gated by fault / blocked
    doCheck(1, 0, 32'h500, 1, 0, "R5");
    doCheck(1, 0, 32'h500, 0, 1, "R5");
    doCheck(1, 0, 32'h500, 1, 1, "R5");
    doCheck(1, 0, 32'h500, 0, 0, "R5");              // slot 1 recorded

    // R7: squash and check in the same cycle
    squashValid = 1; squashSeq = '0;
    doCheck(0, 2, 32'h5C0, 0, 0, "R7");              // slot 3 recorded after clear

    // R9: wrapped search
    doSquash(16'd0, "R9");
    for (int i = 0; i < 5; i++) doRetire("R9");
    for (int i = 0; i < 3; i++) doAlloc("R9");
    doSetAddr(1, 32'h7AB, "R9");
    doSetAddr(2, 32'h7FF, "R9");
    doCheck(0, 6, 32'h700, 0, 0, "R9");              // scan 7,0,1 -> slot 1
    doCheck(0, 2, 32'h700, 0, 0, "R9");              // nothing younger than 2
    for (int i = 0; i < DEPTH; i++) doRetire("R9");  // extra retires ignored
    doRetire("R9");

    // Random phase (R2 and everything together)
    for (int c = 0; c < 6000; c++) begin
      if (mFill < DEPTH && $urandom_range(0, 99) < 40) begin
        allocValid = 1; allocSeq = nextSeq; nextSeq = nextSeq + 1'b1;
      end
      if (mFill > 0 && $urandom_range(0, 99) < 15) retireValid = 1;
      if (mFill > 0 && $urandom_range(0, 99) < 45) begin
        setAddrValid = 1;
        setAddrIdx   = IDX_W'((mHead + int'($urandom_range(0, mFill - 1))) % DEPTH);
        setAddr      = (32'($urandom_range(0, 3)) << 8) | 32'($urandom_range(0, 255));
      end
      if (mFill > 0 && $urandom_range(0, 99) < 45) begin
        checkValid   = 1;
        checkIsLoad  = 1'($urandom_range(0, 1));
        checkIdx     = IDX_W'((mHead + int'($urandom_range(0, mFill - 1))) % DEPTH);
        checkAddr    = (32'($urandom_range(0, 3)) << 8) | 32'($urandom_range(0, 255));
        checkFault   = ($urandom_range(0, 99) < 20);
        queueBlocked = ($urandom_range(0, 99) < 20);
      end
      if ($urandom_range(0, 99) < 12) begin
        squashValid = 1;
        squashSeq   = mHSeq - SEQ_W'($urandom_range(0, 2)) + SEQ_W'($urandom_range(0, 1));
      end
      doCycle("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule